// File: doc/BRIEF.md
# Serial Flash Read Engine

This block fetches a run of bytes from an external serial flash of 1 to 16 Mbit, over a four-wire SPI link. A requester supplies a 24-bit start address and a length. The block then opens a transfer by pulling chip select low. It shifts out the read opcode 0x03 and the address, and then clocks the data back one byte at a time. Each finished byte goes to a valid/ready output stream. The serial clock comes from the system clock. A divider sets the length of each clock phase, and that length is taken from the divider input when a request is accepted.

The serial clock idles low. Every outgoing bit and every chip-select change lines up with a falling serial-clock edge. Read data is also captured on falling edges, not on rising ones. A flash with a slow clock-to-output delay therefore has almost a whole clock period to present each bit. If the consumer stalls, the block parks the serial clock in its low phase with chip select still asserted, so no byte is lost. After the final byte, chip select rises and the block stays busy for two half periods before it takes the next request.

Top module: `spi_flash_rd`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: An accepted request produces one chip-select-low frame. The first 32 rising serial-clock edges carry 0x03 followed by the 24-bit `req_addr`, each field most significant bit first. Inside a frame, `spi_mosi` changes only in the cycle where `spi_sck` falls.
- R3: With H = `div_cfg` + 1, every high phase of `spi_sck` lasts exactly H system cycles, and every low phase inside a frame lasts at least H system cycles.
- R4: A request returns exactly `req_len` + 1 bytes, in address order. Bit 7 of each byte is received first. Data bit k of the frame, counted from 0, is captured on falling edge 33 + k.
- R5: `spi_cs_n` changes only while `spi_sck` is low. It falls only after `spi_sck` has been low for at least one cycle, and it rises in the same cycle that `spi_sck` falls. `spi_sck` is low whenever `spi_cs_n` is 1.
- R6: The value of `div_cfg` is taken when a request is accepted. Changing it during a frame leaves that frame's phase lengths unchanged.
- R7: While `rd_valid` is 1, `spi_sck` does not rise. While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds its value.
- R8: After `spi_cs_n` rises at the end of a frame, `busy` stays 1 for exactly 2·H more cycles. A request is accepted only when `req_ready` is 1, and `req_ready` is the inverse of `busy`.
- R9: The level of `spi_miso` during the 32 opcode and address clocks has no effect on the returned bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_cfg | input | DIV_W | Serial clock half period minus one, in system cycles |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | ADDR_W | First byte address |
| req_len | input | LEN_W | Number of bytes to read, minus one |
| busy | output | 1 | A frame or its closing gap is in progress |
| rd_valid | output | 1 | `rd_data` holds a received byte |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Received byte |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The properties assume a few things about the environment. A request stays valid until it is accepted. The flash drives `spi_miso` only after it sees a falling serial-clock edge, so that level is stable at the system edge where the engine samples it. `div_cfg` and `rd_ready` may change in any cycle. The stimulus keeps to these assumptions in the following ways. The bench's flash model updates its output only in response to a falling serial clock, and it drives a changing pattern during the command and address bits. The bench holds each request until it sees `req_ready`. It switches the divider in the middle of a frame, and it throttles `rd_ready` in long, irregular gaps.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } spi_rd_state_e;

  localparam logic [7:0] RD_OPCODE = 8'h03;

endpackage

// File: rtl/spi_rd_tick.sv
module spi_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  assign tick = (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (!hold) cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_rd_txsr.sv
module spi_rd_txsr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         mosi
);

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;

  assign mosi = sr_q[W-1];

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = load_val;
    else if (shift) sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

endmodule

// File: rtl/spi_rd_rxsr.sv
module spi_rd_rxsr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       shift,
  input  logic       miso,
  output logic       byte_done,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data
);

  logic [2:0] bit_q, bit_d;
  logic [6:0] sr_q, sr_d;
  logic [7:0] out_q, out_d;
  logic       vld_q, vld_d;

  assign byte_done = shift && (bit_q == 3'd7);
  assign rd_valid  = vld_q;
  assign rd_data   = out_q;

  always_comb begin
    bit_d = bit_q;
    sr_d  = sr_q;
    out_d = out_q;
    vld_d = vld_q;
    if (clr)        bit_d = '0;
    else if (shift) bit_d = bit_q + 3'd1;
    if (shift)      sr_d  = {sr_q[5:0], miso};
    if (vld_q && rd_ready) vld_d = 1'b0;
    if (byte_done) begin
      out_d = {sr_q, miso};
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      sr_q  <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      sr_q  <= sr_d;
      out_q <= out_d;
      vld_q <= vld_d;
    end
  end

endmodule

// File: rtl/spi_flash_rd.sv
module spi_flash_rd
  import spi_rd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int HDR_BITS = 8 + ADDR_W;
  localparam int HDR_CW   = $clog2(HDR_BITS + 1);
  localparam logic [HDR_CW-1:0] HDR_LAST = HDR_CW'(HDR_BITS);

  spi_rd_state_e     state_q, state_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic [HDR_CW-1:0] hdr_q, hdr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              gap_half_q, gap_half_d;

  logic tick, hold, accept, rise_ev, fall_ev, hdr_fall, data_fall;
  logic byte_done, last_byte;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign rise_ev   = (state_q == ST_XFER) && !sck_q && tick && !rd_valid;
  assign fall_ev   = (state_q == ST_XFER) && sck_q && tick;
  assign hdr_fall  = fall_ev && (hdr_q != HDR_LAST);
  assign data_fall = fall_ev && (hdr_q == HDR_LAST);
  assign last_byte = byte_done && (left_q == '0);
  assign hold      = (state_q == ST_XFER) && !sck_q && rd_valid;

  spi_rd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .hold  (hold),
    .div   (div_q),
    .tick  (tick)
  );

  spi_rd_txsr #(.W(HDR_BITS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val ({RD_OPCODE, req_addr}),
    .shift    (hdr_fall),
    .mosi     (spi_mosi)
  );

  spi_rd_rxsr u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .shift     (data_fall),
    .miso      (spi_miso),
    .byte_done (byte_done),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always_comb begin
    state_d    = state_q;
    sck_d      = sck_q;
    cs_n_d     = cs_n_q;
    hdr_d      = hdr_q;
    left_d     = left_q;
    div_d      = div_q;
    gap_half_d = gap_half_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d    = ST_XFER;
          cs_n_d     = 1'b0;
          hdr_d      = '0;
          left_d     = req_len;
          div_d      = div_cfg;
          gap_half_d = 1'b0;
        end
      end
      ST_XFER: begin
        if (rise_ev) sck_d = 1'b1;
        if (fall_ev) sck_d = 1'b0;
        if (hdr_fall) hdr_d = hdr_q + 1'b1;
        if (byte_done && !last_byte) left_d = left_q - 1'b1;
        if (last_byte) begin
          cs_n_d  = 1'b1;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick) begin
          gap_half_d = 1'b1;
          if (gap_half_q) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sck_q      <= 1'b0;
      cs_n_q     <= 1'b1;
      hdr_q      <= '0;
      left_q     <= '0;
      div_q      <= '0;
      gap_half_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      sck_q      <= sck_d;
      cs_n_q     <= cs_n_d;
      hdr_q      <= hdr_d;
      left_q     <= left_d;
      div_q      <= div_d;
      gap_half_q <= gap_half_d;
    end
  end

  assign spi_sck   = sck_q;
  assign spi_cs_n  = cs_n_q;
  assign busy      = (state_q != ST_IDLE);
  assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/spi_flash_rd_chk.sv
module spi_flash_rd_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_cfg,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data,
  input logic             spi_sck,
  input logic             spi_cs_n,
  input logic             spi_mosi
);

  localparam int RUN_W = DIV_W + 2;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [DIV_W-1:0] div_lat;
  logic             sck_prev;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] half_len;

  assign half_len = RUN_W'(div_lat) + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lat  <= '0;
      sck_prev <= 1'b0;
      run_q    <= '0;
    end else begin
      if (req_valid && req_ready) div_lat <= div_cfg;
      sck_prev <= spi_sck;
      if (spi_sck != sck_prev)  run_q <= 1;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end

  p_high_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sck) |-> (run_q == half_len));

  p_low_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> (run_q >= half_len));

  p_mosi_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $past(!spi_cs_n) && $changed(spi_mosi)) |-> $fell(spi_sck));

  p_cs_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $fell(spi_sck));

  p_cs_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (!spi_sck && $past(!spi_sck)));

  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !spi_sck) |=> !spi_sck);

  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !spi_cs_n));

  p_gap_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> busy);

endmodule

bind spi_flash_rd spi_flash_rd_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .div_cfg   (div_cfg),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .spi_sck   (spi_sck),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi)
);

// File: tb/spi_flash_rd_tb.sv
`timescale 1ns/1ps
module spi_flash_rd_tb;

  localparam int DIV_W = 4;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] div_cfg = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [23:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             busy;
  logic             rd_valid;
  logic             rd_ready = 1'b0;
  logic [7:0]       rd_data;
  logic             spi_sck;
  logic             spi_cs_n;
  logic             spi_mosi;
  logic             spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_flash_rd #(.DIV_W(DIV_W), .LEN_W(LEN_W), .ADDR_W(24)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  function automatic logic [7:0] fmem(input logic [23:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flash model: launches on falling edges, garbage during header (R9)
  logic [31:0] cap = '0;
  int nrise = 0;
  int nfall = 0;
  always @(negedge spi_cs_n) begin
    nrise = 0;
    nfall = 0;
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (nrise < 32) cap = {cap[30:0], spi_mosi};
    nrise++;
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    nfall++;
    if (nfall >= 32) begin
      logic [7:0] b;
      b = fmem(cap[23:0] + 24'((nfall - 32) / 8));
      spi_miso = b[7 - ((nfall - 32) % 8)];
    end else begin
      spi_miso = nfall[0] ^ nfall[2] ^ 1'b1;
    end
  end

  // monitor state
  int          mode = 0;
  int          exp_h = 1;
  logic [23:0] cur_addr = '0;
  int          nbytes = 0;
  int          data_err = 0;
  int          r3_err = 0;
  int          r7_err = 0;
  int          cs_err = 0;
  int          gap_cnt = 0;
  int          hi_cnt = 0;

  initial begin
    logic prev_sck, prev_cs, prev_vld;
    int cyc;
    prev_sck = 1'b0; prev_cs = 1'b1; prev_vld = 1'b0; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (spi_sck) hi_cnt++;
        if (prev_sck && !spi_sck) begin
          if (hi_cnt != exp_h) r3_err++;
          hi_cnt = 0;
        end
        if (prev_vld && !prev_sck && spi_sck) r7_err++;
        if ((spi_cs_n != prev_cs) && (spi_sck && prev_sck)) cs_err++;
        if (spi_cs_n && spi_sck) cs_err++;
        if (!spi_cs_n) gap_cnt = 0;
        else if (busy) gap_cnt++;
        rd_ready = (mode == 0) ? 1'b1 : ((cyc % 23) == 0);
        if (rd_valid && rd_ready) begin
          if (rd_data != fmem(cur_addr + 24'(nbytes))) begin
            data_err++;
            chk("R4 byte value", 1'b0, int'(rd_data), int'(fmem(cur_addr + 24'(nbytes))));
          end else begin
            chk("R4 byte value", 1'b1, 0, 0);
          end
          nbytes++;
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
        prev_vld = rd_valid;
      end
    end
  end

  task automatic xfer(input logic [23:0] addr, input int len_m1, input int div,
                      input int md, input bit change_div);
    int guard;
    @(negedge clk);
    mode = md; exp_h = div + 1; cur_addr = addr;
    nbytes = 0; data_err = 0; r3_err = 0; r7_err = 0; cs_err = 0; hi_cnt = 0;
    div_cfg = DIV_W'(div); req_addr = addr; req_len = LEN_W'(len_m1);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 busy after accept", busy && !spi_cs_n, int'(busy), 1);
    if (change_div) div_cfg = DIV_W'(div + 5);
    guard = 0;
    while ((busy || nbytes < len_m1 + 1) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk("R2 opcode and address", cap == {8'h03, addr}, int'(cap), int'({8'h03, addr}));
    chk("R3 high phase length", r3_err == 0, r3_err, 0);
    if (change_div) chk("R6 divider latched at start", r3_err == 0, r3_err, 0);
    chk("R4 byte count", nbytes == len_m1 + 1, nbytes, len_m1 + 1);
    chk("R9 header miso ignored", data_err == 0, data_err, 0);
    chk("R5 cs edges", cs_err == 0, cs_err, 0);
    if (md != 0) chk("R7 clock parked while full", r7_err == 0, r7_err, 0);
    chk("R8 closing gap", gap_cnt == 2 * exp_h, gap_cnt, 2 * exp_h);
    chk("R8 ready when idle", req_ready && !busy, int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_n", spi_cs_n == 1'b1, int'(spi_cs_n), 1);
    chk("R1 sck", spi_sck == 1'b0, int'(spi_sck), 0);
    chk("R1 busy", busy == 1'b0, int'(busy), 0);
    chk("R1 rd_valid", rd_valid == 1'b0, int'(rd_valid), 0);
    chk("R1 req_ready", req_ready == 1'b1, int'(req_ready), 1);
    @(posedge clk);
    rst_n <= 1'b1;
    repeat (2) @(negedge clk);
    for (int d = 0; d < 4; d++)
      for (int l = 0; l < 3; l++)
        for (int m = 0; m < 2; m++)
          xfer((d == 3 && l == 2) ? 24'hFFFFFF : 24'({d[7:0], l[7:0], 8'h10 + m[7:0]}),
               l, d, m, 1'b0);
    xfer(24'h0ABCDE, 3, 2, 0, 1'b1);
    xfer(24'h123456, 5, 1, 1, 1'b1);
    xfer(24'h000000, 15, 0, 1, 1'b0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule